// File: doc/BRIEF.md
# Boot ROM Select Lock Register

This block is a write-only control register that decides which memory serves the upper address space of the console. It selects either the internal boot ROM or the cartridge. It snoops CPU writes to a small, mirrored address window at the bottom of the map. That window overlaps the video chip's registers, so the block only observes those writes and never claims or acknowledges them. The other devices on the bus see each write as usual.

While the register is open, every decoded write loads the map choice from one data bit. A second data bit sets a one-way lock. Once the lock is set, the map choice is frozen until the next reset. Writes to the window are still observed while locked, but they change nothing. The selection is judged before the lock takes effect, so the write that sets the lock also applies its own selection.

There are three registered outputs:
- a cartridge-select level,
- a one-cycle strobe telling the ROM switching logic that a new map choice was written,
- the lock status.

Top module: `bootsel_lock`

## Requirements
- R1: During and after a synchronous reset, `cart_sel_o`, `map_chg_o` and `locked_o` are all low, so the boot ROM is selected and the register is open.
- R2: A write is decoded only when `(cpu_addr & 16'hFCFF) <= 16'h001F`. Address bits 9:8 are therefore ignored, which creates mirrors at 0x0100, 0x0200 and 0x0300. A write at any other address leaves all three outputs unchanged and produces no strobe.
- R3: A decoded write while unlocked sets `cart_sel_o` to data bit 2 (1 = cartridge, 0 = boot ROM). The new value is visible after the clock edge that samples the write.
- R4: `map_chg_o` is high for exactly the one cycle after each decoded write made while unlocked. This holds even when the selection does not change, and the strobe is low in every other cycle.
- R5: A decoded write with data bit 0 set raises `locked_o` after that edge. Once high, `locked_o` stays high until reset.
- R6: The write that sets the lock also applies its data bit 2 selection and produces the `map_chg_o` strobe.
- R7: While `locked_o` is high, decoded writes change neither `cart_sel_o` nor `locked_o`, and they produce no strobe.
- R8: With `cpu_we` low, no address or data value has any effect on the outputs.
- R9: Reset clears a set lock, and the next decoded write again updates the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one write per cycle when high |
| cart_sel_o | output | 1 | 1 = cartridge serves the upper space, 0 = boot ROM |
| map_chg_o | output | 1 | One-cycle pulse after each accepted selection write |
| locked_o | output | 1 | Lock status; selection is frozen when high |

## Verification
The selection update and the setting of the lock can fall into the same cycle. The ordering between them decides whether the locking write is still obeyed. This is provoked by directed writes that carry bit 0 and bit 2 together, and by random data on writes into the window. In each case the bench model computes the selection from the lock state held before the edge. A second collision is a write that arrives in the cycle after the lock was set, or after a reset. The bench expects the first of these to be ignored and the second to be obeyed, and it checks the strobe in the same cycle as the selection.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam logic [ADDR_W-1:0] WIN_MASK  = 16'hFCFF;
  localparam logic [ADDR_W-1:0] WIN_LIMIT = 16'h001F;
  localparam int unsigned SEL_BIT   = 2;
  localparam int unsigned LOCK_BIT  = 0;

  typedef enum logic {MAP_BOOT = 1'b0, MAP_CART = 1'b1} map_e;
endpackage

// File: rtl/bootsel_decode.sv
module bootsel_decode #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] MASK  = 16'hFCFF,
  parameter logic [AW-1:0] LIMIT = 16'h001F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output logic          wr_hit_o
);
  logic [AW-1:0] masked;

  assign masked   = addr_i & MASK;
  assign wr_hit_o = we_i && (masked <= LIMIT);

  // R8: a hit needs the write strobe; R2: with default mask, upper bits zero
  assert_hit_needs_we_R8: assert property (@(posedge clk) disable iff (rst)
    wr_hit_o |-> we_i);
  assert_hit_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_o && MASK == 16'hFCFF && LIMIT == 16'h001F)
      |-> (addr_i[AW-1:10] == '0 && addr_i[7:5] == '0));
endmodule

// File: rtl/bootsel_state.sv
module bootsel_state (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit_i,
  input  logic sel_bit_i,
  input  logic lock_bit_i,
  output logic cart_sel_o,
  output logic map_chg_o,
  output logic locked_o
);
  import bootsel_pkg::*;

  map_e map_q;
  logic chg_q;
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q  <= MAP_BOOT;
      chg_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (wr_hit_i) begin
        if (!lock_q) begin
          map_q <= sel_bit_i ? MAP_CART : MAP_BOOT;
          chg_q <= 1'b1;
        end
        if (lock_bit_i) lock_q <= 1'b1;
      end
    end
  end

  assign cart_sel_o = (map_q == MAP_CART);
  assign map_chg_o  = chg_q;
  assign locked_o   = lock_q;

  assert_sel_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && !lock_q) |=> (cart_sel_o == $past(sel_bit_i)));
  assert_strobe_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && !lock_q) |=> map_chg_o);
  assert_strobe_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit_i && !lock_q) |=> !map_chg_o);
  assert_lock_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && lock_bit_i) |=> locked_o);
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);
  assert_sel_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(cart_sel_o));
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_hit_i |=> ($stable(cart_sel_o) && $stable(locked_o)));
endmodule

// File: rtl/bootsel_lock.sv
module bootsel_lock
  import bootsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic              cart_sel_o,
  output logic              map_chg_o,
  output logic              locked_o
);
  logic wr_hit;
  logic unused_data;

  assign unused_data = ^cpu_wdata;

  bootsel_decode #(
    .AW   (ADDR_W),
    .MASK (WIN_MASK),
    .LIMIT(WIN_LIMIT)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (cpu_addr),
    .we_i    (cpu_we),
    .wr_hit_o(wr_hit)
  );

  bootsel_state u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_hit_i  (wr_hit),
    .sel_bit_i (cpu_wdata[SEL_BIT]),
    .lock_bit_i(cpu_wdata[LOCK_BIT]),
    .cart_sel_o(cart_sel_o),
    .map_chg_o (map_chg_o),
    .locked_o  (locked_o)
  );
endmodule

// File: tb/sim_bootsel_lock.sv
module sim_bootsel_lock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cart_sel_o, map_chg_o, locked_o;

  int checks = 0;
  int failures = 0;
  logic m_sel = 0, m_chg = 0, m_lock = 0;

  bootsel_lock u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cart_sel_o(cart_sel_o), .map_chg_o(map_chg_o),
    .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit in_window(logic [15:0] a);
    return (a & 16'hFCFF) <= 16'h001F;
  endfunction

  task automatic check(string req);
    checks++;
    if (cart_sel_o !== m_sel || map_chg_o !== m_chg || locked_o !== m_lock) begin
      failures++;
      $display("FAIL %s: sel/chg/lock actual=%b%b%b expected=%b%b%b", req,
               cart_sel_o, map_chg_o, locked_o, m_sel, m_chg, m_lock);
    end
  endtask

  // drive one cycle, advance the model at the edge, sample 1 time unit later
  task automatic step(logic we, logic [15:0] a, logic [7:0] d, string req);
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    if (rst) begin
      m_sel = 0; m_chg = 0; m_lock = 0;
    end else begin
      m_chg = 0;
      if (we && in_window(a)) begin
        if (!m_lock) begin m_sel = d[2]; m_chg = 1; end
        if (d[0]) m_lock = 1;
      end
    end
    #1;
    check(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, 16'h0005, 8'h05, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #2;
    do_reset();
    step(1'b0, 16'h0000, 8'h00, "R1");                 // reset state
    step(1'b1, 16'h0000, 8'h04, "R3");                 // select cartridge
    step(1'b1, 16'h0104, 8'h04, "R4");                 // same selection, mirror, strobe again
    step(1'b0, 16'h0000, 8'h00, "R4");                 // strobe drops
    step(1'b1, 16'h0020, 8'h00, "R2");                 // just outside window
    step(1'b1, 16'h0300, 8'h00, "R2");                 // mirror hit -> boot ROM
    step(1'b1, 16'h001F, 8'h04, "R2");                 // upper window edge
    step(1'b1, 16'h2000, 8'h00, "R2");                 // far miss
    step(1'b1, 16'h0080, 8'h00, "R2");                 // bit 7 set -> miss
    step(1'b0, 16'h0010, 8'h01, "R8");                 // no strobe -> nothing
    step(1'b1, 16'h0201, 8'h01, "R6");                 // lock write with boot select
    step(1'b1, 16'h0000, 8'h04, "R7");                 // ignored while locked
    step(1'b1, 16'h0005, 8'h05, "R7");
    step(1'b0, 16'h0000, 8'h00, "R5");
    do_reset();
    step(1'b0, 16'h0000, 8'h00, "R9");
    step(1'b1, 16'h0002, 8'h05, "R6");                 // lock + cart together
    step(1'b1, 16'h0002, 8'h00, "R7");
    do_reset();
    step(1'b1, 16'h0001, 8'h04, "R9");                 // open again after reset

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic        w;
      if (($urandom % 97) == 0) begin
        do_reset();
        continue;
      end
      a = $urandom;
      if (($urandom % 3) != 0) a = {6'b0, a[9:8], 3'b0, a[4:0]};
      d = $urandom;
      if (($urandom % 8) != 0) d[0] = 1'b0;       // keep long unlocked runs
      w = ($urandom % 4) != 0;
      step(w, a, d, m_lock ? "R7" : "R3_R4_R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule